// File: doc/BRIEF.md
# Queued Debug Register Access Scan Chain

This block is a 40-bit scan data register that lets an external debugger reach a bank of internal debug registers through queued requests. Each scan carries a 7-bit register address, a 32-bit data word and one direction/status bit. When Update-DR is reached, the block may post the scanned word as a read or write request. The request is then served on the register side after a fixed latency. The debugger learns that the request has finished by capturing the chain again: the status position reads 1 once the block is idle, and after a read the data field holds the value that was fetched. While a request is still in flight, the chain is frozen. It shifts out zeros and discards whatever is shifted in.

The backing bank holds a vector catch register, breakpoint value and control registers, and watchpoint value and control registers. It also provides a read-only view of a program counter sample supplied from outside. The TAP state machine and the instruction decode are not part of the block. The three strobes arrive already qualified for this chain, and both test instructions that select it behave the same way. The breakpoint and watchpoint comparators are not part of the block either; they consume the register values on the output ports.

Top module: `dbg_req_chain`

## Requirements
- R1: Chain order as seen at `scan_out` and as loaded from `scan_in`, least significant first: bit 0 is the status/direction bit, bits 32:1 are the data word, bits 39:33 are the address. Each shift cycle moves `scan_in` into bit 39 and bit 0 appears at `scan_out`.
- R2: A capture cycle loads the block's completion flag into bit 0: 1 when no request is outstanding, 0 while one is in flight.
- R3: An update cycle posts a request only if the preceding capture loaded 1 and the shifted-in address is nonzero. The shifted-in bit 0 selects the direction: 0 for a read, 1 for a write. Address 0 posts nothing.
- R4: After a capture that loaded 0, the chain is frozen until the next capture. `scan_out` stays 0, shifted-in bits are discarded, and the following update posts nothing.
- R5: A capture that loads 1 also loads 0 into the address field. It loads the data field with the result of the most recently completed read, or with 0 if the last completed request was a write.
- R6: Address map: 7 is the vector catch register. 64+i, 80+i, 96+j and 112+j are breakpoint value i, breakpoint control i, watchpoint value j and watchpoint control j respectively, for i < NUM_BRP and j < NUM_WRP. A completed write shows up on the matching output slice, where register i sits at bits i*32+31:i*32.
- R7: Address 8 reads the `pc_sample` input as it stands in the cycle the read completes. A write to address 8 changes no register.
- R8: Any other nonzero address is reserved. A read of it returns 0, and a write to it changes no register.
- R9: A posted request completes exactly LATENCY cycles after the update cycle. Captures taken at the first LATENCY clock edges after the update load 0, and the written register changes at the LATENCY-th edge.
- R10: After reset the completion flag is 1, every backing register is 0 and `scan_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_en | input | 1 | Capture-DR cycle strobe for this chain |
| shift_en | input | 1 | Shift-DR cycle strobe for this chain |
| upd_en | input | 1 | Update-DR cycle strobe for this chain |
| scan_in | input | 1 | Serial data in (TDI) |
| scan_out | output | 1 | Serial data out (TDO), bit 0 of the chain |
| pc_sample | input | 32 | Current program counter sample |
| vcatch | output | 32 | Vector catch register |
| bp_value | output | NUM_BRP*32 | Breakpoint value registers, packed |
| bp_ctrl | output | NUM_BRP*32 | Breakpoint control registers, packed |
| wp_value | output | NUM_WRP*32 | Watchpoint value registers, packed |
| wp_ctrl | output | NUM_WRP*32 | Watchpoint control registers, packed |

## Verification
The bench builds the block with its defaults: six breakpoint pairs, two watchpoint pairs and a latency of three. With these values the highest breakpoint index (85), the highest watchpoint index (97, 113) and the first unused slot past the breakpoint range (70) can all be reached. The short latency lets a capture be placed exactly on the last busy edge and then on the first idle one. It also lets a second scan follow a posted request closely enough to land in the frozen window, which shows whether shifted-in data is discarded there.

// File: rtl/dbg_chain_pkg.sv
package dbg_chain_pkg;

    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 32;
    localparam int CHAIN_W = ADDR_W + DATA_W + 1;

    localparam logic [ADDR_W-1:0] ADR_NULL     = 7'd0;
    localparam logic [ADDR_W-1:0] ADR_VCATCH   = 7'd7;
    localparam logic [ADDR_W-1:0] ADR_PC       = 7'd8;
    localparam logic [ADDR_W-1:0] ADR_BPV_BASE = 7'd64;
    localparam logic [ADDR_W-1:0] ADR_BPC_BASE = 7'd80;
    localparam logic [ADDR_W-1:0] ADR_WPV_BASE = 7'd96;
    localparam logic [ADDR_W-1:0] ADR_WPC_BASE = 7'd112;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              wr;
    } dbg_req_t;

endpackage

// File: rtl/dbg_scan_shifter.sv
module dbg_scan_shifter
    import dbg_chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              shift_i,
    input  logic              upd_i,
    input  logic              tdi_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              tdo_o,
    output logic              req_valid_o,
    output dbg_req_t          req_o
);

    typedef struct packed {
        logic [CHAIN_W-1:0] sr;
        logic               armed;
    } sh_state_t;

    sh_state_t st_d, st_q;

    // next-state logic
    always_comb begin
        st_d        = st_q;
        req_valid_o = 1'b0;
        if (cap_i) begin
            st_d.armed = done_i;
            st_d.sr    = done_i ? {{ADDR_W{1'b0}}, rdata_i, 1'b1} : '0;
        end else if (shift_i) begin
            if (st_q.armed) begin
                st_d.sr = {tdi_i, st_q.sr[CHAIN_W-1:1]};
            end
        end else if (upd_i) begin
            if (st_q.armed && (st_q.sr[CHAIN_W-1 -: ADDR_W] != ADR_NULL)) begin
                req_valid_o = 1'b1;
            end
            st_d.armed = 1'b0;
            st_d.sr    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tdo_o = st_q.sr[0];
    assign req_o = dbg_req_t'(st_q.sr);

    // R4: a chain that is not armed only ever presents zeros
    assert_frozen_zero_R4 : assert property (
        @(posedge clk) disable iff (!rst_n) !st_q.armed |-> !tdo_o
    );

endmodule

// File: rtl/dbg_req_tracker.sv
module dbg_req_tracker
    import dbg_chain_pkg::*;
#(
    parameter int LATENCY = 3
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  dbg_req_t          req_i,
    input  logic [DATA_W-1:0] rf_rdata_i,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] rf_addr_o,
    output logic [DATA_W-1:0] rf_wdata_o,
    output logic              rf_we_o
);

    localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(LATENCY - 1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        dbg_req_t          req;
        logic [DATA_W-1:0] rdata;
    } trk_state_t;

    trk_state_t st_d, st_q;
    logic       finish;

    always_comb begin
        st_d    = st_q;
        finish  = st_q.busy && (st_q.cnt == '0);
        rf_we_o = finish && st_q.req.wr;
        if (issue_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_INIT;
            st_d.req  = req_i;
        end else if (st_q.busy) begin
            if (finish) begin
                st_d.busy  = 1'b0;
                st_d.rdata = st_q.req.wr ? '0 : rf_rdata_i;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o     = !st_q.busy;
    assign rdata_o    = st_q.rdata;
    assign rf_addr_o  = st_q.req.addr;
    assign rf_wdata_o = st_q.req.data;

    // cycle counter used only by the latency check
    logic [CNT_W:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (issue_i) begin
            age_q <= '0;
        end else if (st_q.busy) begin
            age_q <= age_q + 1'b1;
        end
    end

    // R3: the shifter never posts a request while one is outstanding
    assert_no_overlap_R3 : assert property (
        @(posedge clk) disable iff (!rst_n) issue_i |-> !st_q.busy
    );

    // R9: every request stays busy for exactly LATENCY edges
    assert_fixed_latency_R9 : assert property (
        @(posedge clk) disable iff (!rst_n) $fell(st_q.busy) |-> (age_q == (CNT_W+1)'(LATENCY))
    );

endmodule

// File: rtl/dbg_reg_bank.sv
module dbg_reg_bank
    import dbg_chain_pkg::*;
#(
    parameter int NUM_BRP = 6,
    parameter int NUM_WRP = 2
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [DATA_W-1:0]         wdata_i,
    input  logic [DATA_W-1:0]         pc_sample_i,
    output logic [DATA_W-1:0]         rdata_o,
    output logic [DATA_W-1:0]         vcatch_o,
    output logic [NUM_BRP*DATA_W-1:0] bpv_o,
    output logic [NUM_BRP*DATA_W-1:0] bpc_o,
    output logic [NUM_WRP*DATA_W-1:0] wpv_o,
    output logic [NUM_WRP*DATA_W-1:0] wpc_o
);

    typedef struct packed {
        logic [DATA_W-1:0]              vcatch;
        logic [NUM_BRP-1:0][DATA_W-1:0] bpv;
        logic [NUM_BRP-1:0][DATA_W-1:0] bpc;
        logic [NUM_WRP-1:0][DATA_W-1:0] wpv;
        logic [NUM_WRP-1:0][DATA_W-1:0] wpc;
    } bank_t;

    bank_t st_d, st_q;

    logic               vc_hit, pc_hit, wr_hit;
    logic [NUM_BRP-1:0] bpv_hit, bpc_hit;
    logic [NUM_WRP-1:0] wpv_hit, wpc_hit;

    assign vc_hit = (addr_i == ADR_VCATCH);
    assign pc_hit = (addr_i == ADR_PC);

    // address decode, one comparator per implemented slot
    for (genvar gi = 0; gi < NUM_BRP; gi++) begin : g_bp_dec
        assign bpv_hit[gi] = (addr_i == ADR_BPV_BASE + ADDR_W'(gi));
        assign bpc_hit[gi] = (addr_i == ADR_BPC_BASE + ADDR_W'(gi));
    end
    for (genvar gj = 0; gj < NUM_WRP; gj++) begin : g_wp_dec
        assign wpv_hit[gj] = (addr_i == ADR_WPV_BASE + ADDR_W'(gj));
        assign wpc_hit[gj] = (addr_i == ADR_WPC_BASE + ADDR_W'(gj));
    end

    assign wr_hit = vc_hit || (|bpv_hit) || (|bpc_hit) || (|wpv_hit) || (|wpc_hit);

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            if (vc_hit) st_d.vcatch = wdata_i;
            for (int i = 0; i < NUM_BRP; i++) begin
                if (bpv_hit[i]) st_d.bpv[i] = wdata_i;
                if (bpc_hit[i]) st_d.bpc[i] = wdata_i;
            end
            for (int j = 0; j < NUM_WRP; j++) begin
                if (wpv_hit[j]) st_d.wpv[j] = wdata_i;
                if (wpc_hit[j]) st_d.wpc[j] = wdata_i;
            end
        end
    end

    // read multiplexer: reserved addresses fall through to zero
    always_comb begin
        rdata_o = '0;
        if (vc_hit) rdata_o = st_q.vcatch;
        if (pc_hit) rdata_o = pc_sample_i;
        for (int i = 0; i < NUM_BRP; i++) begin
            if (bpv_hit[i]) rdata_o = st_q.bpv[i];
            if (bpc_hit[i]) rdata_o = st_q.bpc[i];
        end
        for (int j = 0; j < NUM_WRP; j++) begin
            if (wpv_hit[j]) rdata_o = st_q.wpv[j];
            if (wpc_hit[j]) rdata_o = st_q.wpc[j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vcatch_o = st_q.vcatch;
    assign bpv_o    = st_q.bpv;
    assign bpc_o    = st_q.bpc;
    assign wpv_o    = st_q.wpv;
    assign wpc_o    = st_q.wpc;

    // R8 (and the PC address of R7): a write that hits no storage leaves the bank untouched
    assert_ignored_write_R8 : assert property (
        @(posedge clk) disable iff (!rst_n) (we_i && !wr_hit) |=> $stable(st_q)
    );

endmodule

// File: rtl/dbg_req_chain.sv
module dbg_req_chain
    import dbg_chain_pkg::*;
#(
    parameter int NUM_BRP = 6,
    parameter int NUM_WRP = 2,
    parameter int LATENCY = 3
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cap_en,
    input  logic                      shift_en,
    input  logic                      upd_en,
    input  logic                      scan_in,
    output logic                      scan_out,
    input  logic [DATA_W-1:0]         pc_sample,
    output logic [DATA_W-1:0]         vcatch,
    output logic [NUM_BRP*DATA_W-1:0] bp_value,
    output logic [NUM_BRP*DATA_W-1:0] bp_ctrl,
    output logic [NUM_WRP*DATA_W-1:0] wp_value,
    output logic [NUM_WRP*DATA_W-1:0] wp_ctrl
);

    logic              req_valid;
    dbg_req_t          req;
    logic              done;
    logic [DATA_W-1:0] cap_data;
    logic [ADDR_W-1:0] rf_addr;
    logic [DATA_W-1:0] rf_wdata;
    logic [DATA_W-1:0] rf_rdata;
    logic              rf_we;

    dbg_scan_shifter u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_i       (cap_en),
        .shift_i     (shift_en),
        .upd_i       (upd_en),
        .tdi_i       (scan_in),
        .done_i      (done),
        .rdata_i     (cap_data),
        .tdo_o       (scan_out),
        .req_valid_o (req_valid),
        .req_o       (req)
    );

    dbg_req_tracker #(.LATENCY(LATENCY)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_i    (req_valid),
        .req_i      (req),
        .rf_rdata_i (rf_rdata),
        .done_o     (done),
        .rdata_o    (cap_data),
        .rf_addr_o  (rf_addr),
        .rf_wdata_o (rf_wdata),
        .rf_we_o    (rf_we)
    );

    dbg_reg_bank #(.NUM_BRP(NUM_BRP), .NUM_WRP(NUM_WRP)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (rf_we),
        .addr_i      (rf_addr),
        .wdata_i     (rf_wdata),
        .pc_sample_i (pc_sample),
        .rdata_o     (rf_rdata),
        .vcatch_o    (vcatch),
        .bpv_o       (bp_value),
        .bpc_o       (bp_ctrl),
        .wpv_o       (wp_value),
        .wpc_o       (wp_ctrl)
    );

endmodule

// File: tb/dbg_req_chain_test.sv
module dbg_req_chain_test;

    localparam int NB = 6;
    localparam int NW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cap_en = 1'b0, shift_en = 1'b0, upd_en = 1'b0, scan_in = 1'b0;
    logic          scan_out;
    logic [31:0]   pc_sample = '0;
    logic [31:0]   vcatch;
    logic [NB*32-1:0] bp_value, bp_ctrl;
    logic [NW*32-1:0] wp_value, wp_ctrl;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [39:0] exp_q[$];
    string       tag_q[$];
    logic [39:0] got_w;
    event        scan_done;

    always #5 clk = ~clk;

    dbg_req_chain #(.NUM_BRP(NB), .NUM_WRP(NW), .LATENCY(3)) uut (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .shift_en(shift_en), .upd_en(upd_en),
        .scan_in(scan_in), .scan_out(scan_out), .pc_sample(pc_sample), .vcatch(vcatch),
        .bp_value(bp_value), .bp_ctrl(bp_ctrl), .wp_value(wp_value), .wp_ctrl(wp_ctrl)
    );

    function automatic logic [39:0] rdy(input logic [31:0] d);
        return {7'd0, d, 1'b1};
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: queue the expected capture word, then run one DR pass
    task automatic scan(input logic [6:0] a, input logic [31:0] d, input logic rw,
                        input int idle, input logic [39:0] exp, input string tag);
        logic [39:0] din;
        din = {a, d, rw};
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        repeat (idle) @(negedge clk);
        cap_en = 1'b1;
        @(negedge clk);
        cap_en   = 1'b0;
        shift_en = 1'b1;
        for (int i = 0; i < 40; i++) begin
            scan_in  = din[i];
            got_w[i] = scan_out;
            @(negedge clk);
        end
        shift_en = 1'b0;
        upd_en   = 1'b1;
        @(negedge clk);
        upd_en = 1'b0;
        -> scan_done;
    endtask

    // monitor: compare each finished scan against the scoreboard head
    initial begin
        forever begin
            @(scan_done);
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL scoreboard empty actual=%h expected=none", got_w);
            end else begin
                chk({24'd0, got_w}, {24'd0, exp_q.pop_front()}, tag_q.pop_front());
            end
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(64'(vcatch), 64'd0, "R10 vcatch after reset");
        chk(64'(|bp_value | |bp_ctrl | |wp_value | |wp_ctrl), 64'd0, "R10 bank cleared");
        chk(64'(scan_out), 64'd0, "R10 scan_out low");
        scan(7'd0, 32'd0, 1'b0, 0, rdy(32'd0), "R2 R10 idle capture");

        // R9 write latency at the port
        scan(7'd7, 32'hA5A5_1234, 1'b1, 0, rdy(32'd0), "R3 post vcatch write");
        @(negedge clk);
        @(negedge clk);
        chk(64'(vcatch), 64'd0, "R9 vcatch unchanged before last edge");
        @(negedge clk);
        chk(64'(vcatch), 64'hA5A5_1234, "R9 R6 vcatch written at latency");
        scan(7'd0, 32'd0, 1'b0, 0, rdy(32'd0), "R5 write completion data zero");

        // R4 frozen chain while busy
        scan(7'd64, 32'h1111_2222, 1'b1, 0, rdy(32'd0), "R3 post bp value 0 write");
        scan(7'd65, 32'hDEAD_BEEF, 1'b1, 0, 40'd0, "R4 busy scan returns zeros");
        scan(7'd0, 32'd0, 1'b0, 4, rdy(32'd0), "R2 idle after completion");
        chk(64'(bp_value[31:0]), 64'h1111_2222, "R6 bp value 0");
        chk(64'(bp_value[63:32]), 64'd0, "R4 shifted-in request discarded");

        // R9 capture on the last busy edge, R5 read data
        scan(7'd64, 32'd0, 1'b0, 0, rdy(32'd0), "R3 post bp value 0 read");
        scan(7'd0, 32'd0, 1'b0, 2, 40'd0, "R9 still busy at latency edge");
        scan(7'd0, 32'd0, 1'b0, 0, rdy(32'h1111_2222), "R5 read data captured");

        // R3 address zero posts nothing even with direction bit set
        scan(7'd0, 32'hFFFF_FFFF, 1'b1, 0, rdy(32'h1111_2222), "R3 null request");
        scan(7'd0, 32'd0, 1'b0, 0, rdy(32'h1111_2222), "R3 address zero left chain idle");

        // R7 PC sample read, write ignored
        pc_sample = 32'hCAFE_F00D;
        scan(7'd8, 32'd0, 1'b0, 0, rdy(32'h1111_2222), "R7 post pc read");
        scan(7'd0, 32'd0, 1'b0, 4, rdy(32'hCAFE_F00D), "R7 pc sample read");
        scan(7'd8, 32'h5555_5555, 1'b1, 0, rdy(32'hCAFE_F00D), "R7 post pc write");
        pc_sample = 32'h0BAD_0004;
        scan(7'd8, 32'd0, 1'b0, 4, rdy(32'd0), "R7 pc write completed");
        scan(7'd0, 32'd0, 1'b0, 4, rdy(32'h0BAD_0004), "R7 pc write ignored");

        // R8 reserved addresses
        scan(7'd9, 32'h7777_7777, 1'b1, 0, rdy(32'h0BAD_0004), "R8 post reserved write");
        scan(7'd70, 32'h8888_8888, 1'b1, 4, rdy(32'd0), "R8 post unused bp slot write");
        scan(7'd9, 32'd0, 1'b0, 4, rdy(32'd0), "R8 post reserved read");
        scan(7'd0, 32'd0, 1'b0, 4, rdy(32'd0), "R8 reserved read zero");
        chk(64'(vcatch), 64'hA5A5_1234, "R8 R7 vcatch untouched");
        chk(64'(bp_value[NB*32-1:64]), 64'd0, "R8 upper bp values untouched");
        chk(64'(bp_value[63:0]), {32'd0, 32'h1111_2222}, "R8 lower bp values untouched");

        // R6 edges of the map, R1 bit order through read-back
        scan(7'd85, 32'h8000_0001, 1'b1, 4, rdy(32'd0), "R6 post bp ctrl 5 write");
        scan(7'd97, 32'h0F0F_0F0F, 1'b1, 4, rdy(32'd0), "R6 post wp value 1 write");
        scan(7'd113, 32'h1357_9BDF, 1'b1, 4, rdy(32'd0), "R6 post wp ctrl 1 write");
        scan(7'd82, 32'h2468_ACE0, 1'b1, 4, rdy(32'd0), "R6 post bp ctrl 2 write");
        scan(7'd85, 32'd0, 1'b0, 4, rdy(32'd0), "R6 post bp ctrl 5 read");
        scan(7'd0, 32'd0, 1'b0, 4, rdy(32'h8000_0001), "R1 R5 bit order of read-back");
        chk(64'(bp_ctrl[191:160]), 64'h8000_0001, "R6 bp ctrl 5");
        chk(64'(bp_ctrl[95:64]), 64'h2468_ACE0, "R6 bp ctrl 2");
        chk(64'(wp_value[63:32]), 64'h0F0F_0F0F, "R6 wp value 1");
        chk(64'(wp_ctrl[63:32]), 64'h1357_9BDF, "R6 wp ctrl 1");
        chk(64'(wp_value[31:0] | wp_ctrl[31:0]), 64'd0, "R6 wp slot 0 untouched");

        @(negedge clk);
        #1;
        if (exp_q.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule